// File: doc/BRIEF.md
# Big-Endian Load/Store Lane Aligner

This block sits between a register datapath and a word-wide data memory that is addressed in bytes. It forms the effective address of an access by adding a sign-extended byte offset to a register base. On a load it takes the full memory word and extracts the addressed byte, halfword or word, then widens it to the register width. Sign or zero fill is chosen by the access's signedness. On a store it moves the low byte or halfword of the source register onto the memory lanes the address points at and raises the matching per-byte write enables.

Lanes are numbered big-endian: the byte at the lowest address of a word is the most significant one. Halfword and word accesses must be naturally aligned. An access that breaks this raises a misalign flag and blocks every write enable. The block is purely combinational, so the memory, the register file and any trap logic around it take its outputs in the same cycle.

Top module: `ls_align_top`

## Requirements
- R1: `effAddr` equals `baseAddr` plus `addrOffset` sign-extended to the address width, with the carry out of the top bit dropped.
- R2: `accSize` encodes 2'b00 as byte, 2'b01 as halfword and 2'b10 or 2'b11 as word. An aligned word load returns `memRdata` unchanged on `loadData`.
- R3: Lane order is big-endian. A byte at effAddr[1:0] = 0 comes from memRdata[31:24] and one at 3 comes from memRdata[7:0]. A halfword at effAddr[1:0] = 0 comes from memRdata[31:16] and one at 2 comes from memRdata[15:0].
- R4: With `accSigned` = 1, a byte or halfword load copies the top bit of the extracted value into every higher bit of `loadData`.
- R5: With `accSigned` = 0, a byte or halfword load fills every bit of `loadData` above the extracted value with zero.
- R6: On a store, `memWdata` holds regWdata[7:0] (byte) or regWdata[15:0] (halfword) on the lanes chosen by R3, with all other lanes zero. A word store copies all of `regWdata`.
- R7: `memByteEn` bit 3 guards memWdata[31:24] (lane 0) and bit 0 guards memWdata[7:0]. An aligned store sets one bit for a byte, two adjacent bits for a halfword and all four bits for a word, covering the addressed lanes.
- R8: `misalign` is 1 for a halfword with effAddr[0] = 1 or a word with effAddr[1:0] != 0, and 0 otherwise. Byte accesses never set it.
- R9: While `misalign` is 1, `memByteEn` is all zero and `loadData` is zero.
- R10: When `accStore` = 0 (a load), `memByteEn` is all zero at every address and size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| baseAddr | input | ADDR_W (32) | Register base of the effective address |
| addrOffset | input | OFFS_W (16) | Signed byte offset |
| accSize | input | 2 | Access size: 00 byte, 01 halfword, 1x word |
| accSigned | input | 1 | 1 sign-extends, 0 zero-extends narrow loads |
| accStore | input | 1 | 1 store, 0 load |
| memRdata | input | DATA_W (32) | Word read from memory |
| regWdata | input | DATA_W (32) | Source register for stores |
| effAddr | output | ADDR_W (32) | Effective byte address |
| memWdata | output | DATA_W (32) | Lane-placed store data |
| memByteEn | output | DATA_W/8 (4) | Per-byte write enables, bit 3 = lane 0 |
| loadData | output | DATA_W (32) | Extracted, extended load result |
| misalign | output | 1 | Alignment fault flag |

## Verification
The bench builds the block with its defaults: a 32-bit data word, a 32-bit address and a 16-bit offset. The 16-bit offset lets negative offsets and base-plus-offset sums that wrap past zero reach the low address bits, so lane choice is driven through the adder and not set directly. With four lanes, every offset of every size, both fills and both directions can be swept in full. Data patterns with the top bit set and clear in each lane separate sign fill from zero fill.

// File: rtl/ls_align_pkg.sv
package ls_align_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_WALT = 2'b11
  } accSize_e;

  // strobes from the control to the datapath
  typedef struct packed {
    logic misalign;
    logic sizeByte;
    logic sizeHalf;
    logic sizeWord;
    logic extSign;
    logic writeGo;
  } laneCtrl_t;

endpackage

// File: rtl/ls_lane_ctrl.sv
module ls_lane_ctrl
  import ls_align_pkg::*;
#(
  parameter int LSB_W = 2
) (
  input  logic [1:0]       accSize,
  input  logic             accSigned,
  input  logic             accStore,
  input  logic [LSB_W-1:0] addrLow,
  output laneCtrl_t        ctrl
);

  logic isByte, isHalf, isWord;
  logic badAlign;

  always_comb begin
    isByte = (accSize == SZ_BYTE);
    isHalf = (accSize == SZ_HALF);
    isWord = accSize[1];
    badAlign = (isHalf && addrLow[0]) || (isWord && (addrLow != '0));
  end

  always_comb begin
    ctrl          = '0;
    ctrl.sizeByte = isByte;
    ctrl.sizeHalf = isHalf;
    ctrl.sizeWord = isWord;
    ctrl.extSign  = accSigned;
    ctrl.misalign = badAlign;
    ctrl.writeGo  = accStore && !badAlign;
  end

  // exactly one size strobe at a time
  always_comb begin
    if (!$isunknown(accSize))
      p_one_size_r2: assert ($countones({ctrl.sizeByte, ctrl.sizeHalf, ctrl.sizeWord}) == 1)
        else $error("size strobes not one-hot");
    // byte accesses can never be misaligned
    if (!$isunknown(accSize))
      p_byte_aligned_r8: assert (!(ctrl.sizeByte && ctrl.misalign))
        else $error("byte access flagged misaligned");
  end

endmodule

// File: rtl/ls_lane_datapath.sv
module ls_lane_datapath
  import ls_align_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NB     = DATA_W / 8,
  parameter int LSB_W  = $clog2(NB)
) (
  input  laneCtrl_t         ctrl,
  input  logic [LSB_W-1:0]  addrLow,
  input  logic [DATA_W-1:0] memRdata,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] memWdata,
  output logic [NB-1:0]     memByteEn,
  output logic [DATA_W-1:0] loadData
);

  logic [LSB_W-1:0]  shiftLanes;
  logic [DATA_W-1:0] rawShift;
  logic [DATA_W-1:0] storeSrc;
  logic [NB-1:0]     laneHit;
  logic              signBit;

  // lanes to move so the addressed item lands at the bottom (big-endian)
  always_comb begin
    if (ctrl.sizeByte)
      shiftLanes = LSB_W'(NB - 1) - addrLow;
    else if (ctrl.sizeHalf)
      shiftLanes = LSB_W'(NB - 2) - addrLow;
    else
      shiftLanes = '0;
  end

  always_comb begin
    rawShift = memRdata >> {shiftLanes, 3'b000};
    signBit  = 1'b0;
    if (ctrl.misalign) begin
      loadData = '0;
    end else if (ctrl.sizeByte) begin
      signBit  = ctrl.extSign & rawShift[7];
      loadData = {{(DATA_W-8){signBit}}, rawShift[7:0]};
    end else if (ctrl.sizeHalf) begin
      signBit  = ctrl.extSign & rawShift[15];
      loadData = {{(DATA_W-16){signBit}}, rawShift[15:0]};
    end else begin
      loadData = rawShift;
    end
  end

  always_comb begin
    if (ctrl.sizeByte)
      storeSrc = DATA_W'(regWdata[7:0]);
    else if (ctrl.sizeHalf)
      storeSrc = DATA_W'(regWdata[15:0]);
    else
      storeSrc = regWdata;
    memWdata = storeSrc << {shiftLanes, 3'b000};
  end

  // lane k is the byte at address offset k; its enable bit is NB-1-k
  for (genvar k = 0; k < NB; k++) begin : g_lane
    always_comb begin
      laneHit[k] = ctrl.sizeWord
                 || (ctrl.sizeByte && (addrLow == LSB_W'(k)))
                 || (ctrl.sizeHalf && ((addrLow >> 1) == LSB_W'(k >> 1)));
      memByteEn[NB-1-k] = ctrl.writeGo && laneHit[k];
    end
  end

  always_comb begin
    if (!$isunknown(ctrl)) begin
      p_no_en_misalign_r9: assert (!(ctrl.misalign && (memByteEn != '0)))
        else $error("write enables while misaligned");
      p_no_en_load_r10: assert (ctrl.writeGo || (memByteEn == '0))
        else $error("write enables on a load");
      p_en_count_r7: assert (!ctrl.writeGo ||
          ($countones(memByteEn) == (ctrl.sizeByte ? 1 : ctrl.sizeHalf ? 2 : NB)))
        else $error("wrong number of write enables");
      p_zero_fill_r5: assert (!(ctrl.sizeByte && !ctrl.extSign) || (loadData[DATA_W-1:8] == '0))
        else $error("unsigned byte load not zero filled");
      p_sign_fill_r4: assert (!(ctrl.sizeByte && ctrl.extSign && !ctrl.misalign) ||
          (loadData[DATA_W-1:8] == {(DATA_W-8){loadData[7]}}))
        else $error("signed byte load not sign filled");
    end
  end

endmodule

// File: rtl/ls_align_top.sv
module ls_align_top
  import ls_align_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int OFFS_W = 16,
  localparam int NB    = DATA_W / 8,
  localparam int LSB_W = $clog2(NB)
) (
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [OFFS_W-1:0] addrOffset,
  input  logic [1:0]        accSize,
  input  logic              accSigned,
  input  logic              accStore,
  input  logic [DATA_W-1:0] memRdata,
  input  logic [DATA_W-1:0] regWdata,
  output logic [ADDR_W-1:0] effAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic [NB-1:0]     memByteEn,
  output logic [DATA_W-1:0] loadData,
  output logic              misalign
);

  laneCtrl_t ctrl;

  always_comb
    effAddr = baseAddr + {{(ADDR_W-OFFS_W){addrOffset[OFFS_W-1]}}, addrOffset};

  ls_lane_ctrl #(.LSB_W(LSB_W)) ctrl_i (
    .accSize  (accSize),
    .accSigned(accSigned),
    .accStore (accStore),
    .addrLow  (effAddr[LSB_W-1:0]),
    .ctrl     (ctrl)
  );

  ls_lane_datapath #(.DATA_W(DATA_W), .NB(NB), .LSB_W(LSB_W)) dp_i (
    .ctrl     (ctrl),
    .addrLow  (effAddr[LSB_W-1:0]),
    .memRdata (memRdata),
    .regWdata (regWdata),
    .memWdata (memWdata),
    .memByteEn(memByteEn),
    .loadData (loadData)
  );

  always_comb misalign = ctrl.misalign;

endmodule

// File: tb/ls_align_top_tb_top.sv
module ls_align_top_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic [31:0] baseAddr;
  logic [15:0] addrOffset;
  logic [1:0]  accSize;
  logic        accSigned, accStore;
  logic [31:0] memRdata, regWdata;
  logic [31:0] effAddr, memWdata, loadData;
  logic [3:0]  memByteEn;
  logic        misalign;

  int nRun = 0;
  int nFail = 0;
  bit done = 0;

  ls_align_top dut_i (
    .baseAddr(baseAddr), .addrOffset(addrOffset), .accSize(accSize),
    .accSigned(accSigned), .accStore(accStore), .memRdata(memRdata),
    .regWdata(regWdata), .effAddr(effAddr), .memWdata(memWdata),
    .memByteEn(memByteEn), .loadData(loadData), .misalign(misalign)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    nRun++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // drive on falling edge, sample one ns later
  task automatic apply(input logic [31:0] b, input logic [15:0] o, input logic [1:0] sz,
                       input logic sg, input logic st, input logic [31:0] rd,
                       input logic [31:0] wd);
    @(negedge clk);
    baseAddr = b; addrOffset = o; accSize = sz; accSigned = sg;
    accStore = st; memRdata = rd; regWdata = wd;
    #1;
  endtask

  // reference: byte array view of memory word, big-endian lane k = address k
  function automatic logic [31:0] expLoad(logic [31:0] w, logic [1:0] a, logic [1:0] sz, logic sg);
    logic [7:0] by [4];
    logic [15:0] h;
    for (int k = 0; k < 4; k++) by[k] = w[31-8*k -: 8];
    if (sz == 2'b00) return sg ? {{24{by[a][7]}}, by[a]} : {24'h0, by[a]};
    if (sz == 2'b01) begin
      if (a[0]) return 32'h0;
      h = {by[a], by[a+1]};
      return sg ? {{16{h[15]}}, h} : {16'h0, h};
    end
    if (a != 0) return 32'h0;
    return w;
  endfunction

  task automatic t_reset;
    apply(32'h0, 16'h0, 2'b00, 1'b0, 1'b0, 32'h0, 32'h0);
    chk("R10 idle enables", {28'h0, memByteEn}, 32'h0);
    chk("R8 idle misalign", {31'h0, misalign}, 32'h0);
    chk("R1 idle address", effAddr, 32'h0);
  endtask

  task automatic t_addr;
    apply(32'h0000_1000, 16'hFFFC, 2'b10, 1'b0, 1'b0, 32'h0, 32'h0);
    chk("R1 negative offset", effAddr, 32'h0000_0FFC);
    apply(32'h0000_0002, 16'h8000, 2'b00, 1'b0, 1'b0, 32'h0, 32'h0);
    chk("R1 wrap below zero", effAddr, 32'hFFFF_8002);
    apply(32'hFFFF_FFFF, 16'h0003, 2'b00, 1'b0, 1'b0, 32'h0, 32'h0);
    chk("R1 carry dropped", effAddr, 32'h0000_0002);
  endtask

  task automatic t_loads(input logic [31:0] pat);
    for (int a = 0; a < 4; a++)
      for (int sz = 0; sz < 4; sz++)
        for (int sg = 0; sg < 2; sg++) begin
          // offset reaches address a through the adder from base 0x103
          apply(32'h0000_0103, 16'(a - 3), 2'(sz), 1'(sg), 1'b0, pat, 32'hDEAD_BEEF);
          chk(sz >= 2 ? "R2 word load" : (sg ? "R3/R4 signed load" : "R3/R5 unsigned load"),
              loadData, expLoad(pat, 2'(a), 2'(sz), 1'(sg)));
          chk("R10 load no enables", {28'h0, memByteEn}, 32'h0);
        end
  endtask

  task automatic t_stores(input logic [31:0] src);
    logic [31:0] ew;
    logic [3:0]  ee;
    for (int a = 0; a < 4; a++)
      for (int sz = 0; sz < 3; sz++) begin
        apply(32'h0000_2000, 16'(a), 2'(sz), 1'b1, 1'b1, 32'h5555_5555, src);
        ew = 32'h0; ee = 4'h0;
        if (sz == 0) begin
          ew[31-8*a -: 8] = src[7:0]; ee[3-a] = 1'b1;
        end else if (sz == 1 && a % 2 == 0) begin
          ew[31-8*a -: 16] = src[15:0]; ee[3-a] = 1'b1; ee[2-a] = 1'b1;
        end else if (sz == 2 && a == 0) begin
          ew = src; ee = 4'hF;
        end
        chk("R7/R9 store enables", {28'h0, memByteEn}, {28'h0, ee});
        if (ee != 0) chk("R6 store data", memWdata, ew);
        chk("R8 store misalign", {31'h0, misalign}, {31'h0, ee == 0});
      end
  endtask

  task automatic t_misalign;
    apply(32'h0000_0001, 16'h0, 2'b01, 1'b1, 1'b1, 32'hFFFF_FFFF, 32'h1234_5678);
    chk("R8 odd halfword", {31'h0, misalign}, 32'h1);
    chk("R9 odd halfword enables", {28'h0, memByteEn}, 32'h0);
    apply(32'h0000_0002, 16'h0, 2'b11, 1'b0, 1'b0, 32'hFFFF_FFFF, 32'h0);
    chk("R8 word at 2", {31'h0, misalign}, 32'h1);
    chk("R9 misaligned load data", loadData, 32'h0);
    apply(32'h0000_0003, 16'h0, 2'b00, 1'b1, 1'b1, 32'h0, 32'h0000_00A5);
    chk("R8 byte never misaligned", {31'h0, misalign}, 32'h0);
    chk("R7 byte at 3 enable", {28'h0, memByteEn}, 32'h1);
  endtask

  initial begin
    baseAddr = '0; addrOffset = '0; accSize = '0; accSigned = 0; accStore = 0;
    memRdata = '0; regWdata = '0;
    repeat (2) @(posedge clk);
    rstN = 1'b1;
    t_reset();
    t_addr();
    t_loads(32'h80FF_7F01);
    t_loads(32'h12A4_C35E);
    t_stores(32'hCAFE_F00D);
    t_stores(32'h0102_8384);
    t_misalign();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nRun++; nFail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

endmodule